// File: doc/BRIEF.md
# I2C Master Byte Transmitter

This block drives an open-drain two-wire bus as a write-only master. The host first loads a byte, the 7-bit target address with a zero direction bit in the least significant position, and then pulses a start command. The block pulls SDA low while SCL is high to form a START condition. It then clocks out the byte, most significant bit first, and follows it with an acknowledge clock when that mode is selected. When a byte is finished, the engine parks with SCL held low. Each new byte the host writes is clocked out at once, and no further command is needed.

A stop request may be armed at any time during a transfer. Once it is armed, the engine produces a STOP condition at the end of the byte in flight, or at once if the engine is already parked. This happens whether or not the target acknowledged. A target that does not acknowledge is recorded in a status flag. The block never drives either line high: it only outputs a pull-low enable for each wire. The SCL half-period is a whole number of system clocks. A select input chooses between a standard-rate divider and a fast-rate divider, and both are parameters.

Top module: `i2c_tx_engine`

## Requirements
- R1: After reset, and at any time the engine is idle, `scl_oe` and `sda_oe` are 0 and `busy` is 0. `nack` is 0 after reset.
- R2: A `start_cmd` pulse sampled while idle with `en` high sets `busy` and `sda_oe` on the next clock edge while `scl_oe` stays 0. `scl_oe` first goes to 1 exactly one half-period after that edge.
- R3: Each byte is sent most significant bit first, with its bits sampled on SCL rising edges. In acknowledge mode (`ack_mode`=1), a ninth SCL pulse follows with SDA released. If the target pulls SDA low in that pulse, `nack` stays 0.
- R4: While SCL is released high for two consecutive cycles, SDA changes only to form a START (falling, from idle) or a STOP (rising, inside a transfer). SDA never changes on the same cycle as SCL.
- R5: A `data_wr` pulse while the engine is parked loads `data_in` and clocks it out with no other command. A `data_wr` pulse while a byte is being clocked is ignored: the byte on the wire is unchanged and no extra byte follows.
- R6: A `stop_arm` pulse while busy makes the engine finish the current byte and then produce a STOP: SCL is released, then SDA is released. `busy` falls one half-period later with both lines released. A `stop_arm` pulse while idle is ignored.
- R7: SDA sampled high at the end of the ninth pulse sets `nack`, which the next START clears. With a stop armed, the engine then sends a STOP. Without one, it parks with SCL held low.
- R8: In no-acknowledge mode (`ack_mode`=0), each byte takes exactly eight SCL pulses and no ninth clock is produced.
- R9: Every SCL high and low half lasts `HALF_STD` system clocks when `fast_sel`=0 and `HALF_FAST` system clocks when `fast_sel`=1. The defaults are 1000 and 250 at a 200 MHz system clock, which give 100 kHz and 400 kHz. `fast_sel` and `ack_mode` are held stable during a transfer.
- R10: A `start_cmd` pulse while `en` is 0 is ignored, and the bus stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Engine enable; gates the start command |
| fast_sel | input | 1 | 0: standard-rate half-period, 1: fast-rate half-period |
| ack_mode | input | 1 | 1: ninth acknowledge clock sampled, 0: no ninth clock |
| start_cmd | input | 1 | Pulse: START then send the loaded byte |
| stop_arm | input | 1 | Pulse: request a STOP after the current byte |
| data_wr | input | 1 | Pulse: load `data_in` (and send it when parked) |
| data_in | input | 8 | Byte to load into the shift register |
| sda_in | input | 1 | Sensed level of the SDA wire |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | High from START until the STOP has completed |
| nack | output | 1 | Target left SDA high during the acknowledge clock |

## Verification
`busy` and the START pull on SDA appear one clock after the edge that samples `start_cmd`. The first SCL low follows exactly one half-period later, so the bench checks that SCL is still released after half minus one cycles and pulled one cycle after that. Every following SCL level is held for exactly one half-period. A bus monitor counts, on falling system-clock edges, the samples during which SCL is high and compares each run with the selected half. `nack` settles on the edge that ends the ninth high half, and `busy` drops one half after SDA is released. The bench therefore reads those results only once it has seen the engine parked or idle, always sampling on falling clock edges while it drives inputs.

// File: rtl/i2c_tx_pkg.sv
package i2c_tx_pkg;

   localparam int unsigned BYTE_W = 8;
   localparam int unsigned BIT_W  = $clog2(BYTE_W + 1);

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_LO,
      ST_HI,
      ST_WAIT,
      ST_STOP_A,
      ST_STOP_B,
      ST_STOP_C
   } tx_state_e;

endpackage

// File: rtl/i2c_tx_clkdiv.sv
module i2c_tx_clkdiv #(
   parameter int unsigned HALF_STD  = 1000,
   parameter int unsigned HALF_FAST = 250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic fast_sel,
   output logic tick,
   output logic mid
);

   localparam int unsigned CW = $clog2(HALF_STD + 1);
   localparam logic [CW-1:0] STD_TERM  = CW'(HALF_STD - 1);
   localparam logic [CW-1:0] FAST_TERM = CW'(HALF_FAST - 1);
   localparam logic [CW-1:0] STD_MID   = CW'(HALF_STD / 2);
   localparam logic [CW-1:0] FAST_MID  = CW'(HALF_FAST / 2);

   generate
      if (HALF_FAST < 4) begin : g_bad_fast
         $error("HALF_FAST must be at least 4");
      end
      if (HALF_STD <= HALF_FAST) begin : g_bad_order
         $error("HALF_STD must exceed HALF_FAST");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] term;
   logic [CW-1:0] mid_pt;

   assign term   = fast_sel ? FAST_TERM : STD_TERM;
   assign mid_pt = fast_sel ? FAST_MID : STD_MID;
   assign tick   = run && (cnt_q == term);
   assign mid    = run && (cnt_q == mid_pt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (!run || tick)   cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/i2c_tx_shreg.sv
module i2c_tx_shreg #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         shift,
   input  logic [W-1:0] din,
   output logic         msb
);

   generate
      if (W < 2) begin : g_bad_width
         $error("shift register needs at least two bits");
      end
   endgenerate

   logic [W-1:0] q;

   assign msb = q[W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (load)   q <= din;
      else if (shift)  q <= {q[W-2:0], 1'b0};
   end

endmodule

// File: rtl/i2c_tx_engine.sv
module i2c_tx_engine
   import i2c_tx_pkg::*;
#(
   parameter int unsigned HALF_STD  = 1000,
   parameter int unsigned HALF_FAST = 250
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              fast_sel,
   input  logic              ack_mode,
   input  logic              start_cmd,
   input  logic              stop_arm,
   input  logic              data_wr,
   input  logic [BYTE_W-1:0] data_in,
   input  logic              sda_in,
   output logic              scl_oe,
   output logic              sda_oe,
   output logic              busy,
   output logic              nack
);

   localparam logic [BIT_W-1:0] ACK_IDX  = BIT_W'(BYTE_W);
   localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(BYTE_W - 1);

   tx_state_e        state_q;
   logic [BIT_W-1:0] bit_q;
   logic             sda_q;
   logic             nack_q;
   logic             stop_pend_q;

   logic run, tick, mid, msb;
   logic load_ok, do_load, do_shift, last_bit;

   assign run      = (state_q != ST_IDLE) && (state_q != ST_WAIT);
   assign load_ok  = (state_q == ST_IDLE) || (state_q == ST_WAIT);
   assign do_load  = data_wr && load_ok;
   assign do_shift = (state_q == ST_HI) && tick && (bit_q < ACK_IDX);
   assign last_bit = ack_mode ? (bit_q == ACK_IDX) : (bit_q == LAST_IDX);

   i2c_tx_clkdiv #(
      .HALF_STD (HALF_STD),
      .HALF_FAST(HALF_FAST)
   ) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .fast_sel(fast_sel),
      .tick    (tick),
      .mid     (mid)
   );

   i2c_tx_shreg #(
      .W(BYTE_W)
   ) u_shreg (
      .clk  (clk),
      .rst_n(rst_n),
      .load (do_load),
      .shift(do_shift),
      .din  (data_in),
      .msb  (msb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         bit_q       <= '0;
         sda_q       <= 1'b0;
         nack_q      <= 1'b0;
         stop_pend_q <= 1'b0;
      end else begin
         if (state_q == ST_IDLE) stop_pend_q <= 1'b0;
         else if (stop_arm)      stop_pend_q <= 1'b1;

         case (state_q)
            ST_IDLE: begin
               sda_q <= 1'b0;
               if (start_cmd && en) begin
                  state_q <= ST_START;
                  sda_q   <= 1'b1;
                  bit_q   <= '0;
                  nack_q  <= 1'b0;
               end
            end
            ST_START: begin
               if (tick) begin
                  state_q <= ST_LO;
                  bit_q   <= '0;
               end
            end
            ST_LO: begin
               if (mid) sda_q <= (bit_q == ACK_IDX) ? 1'b0 : ~msb;
               if (tick) state_q <= ST_HI;
            end
            ST_HI: begin
               if (tick) begin
                  if (bit_q == ACK_IDX) nack_q <= sda_in;
                  if (last_bit) begin
                     bit_q   <= '0;
                     state_q <= stop_pend_q ? ST_STOP_A : ST_WAIT;
                  end else begin
                     bit_q   <= bit_q + 1'b1;
                     state_q <= ST_LO;
                  end
               end
            end
            ST_WAIT: begin
               if (data_wr)          state_q <= ST_LO;
               else if (stop_pend_q) state_q <= ST_STOP_A;
            end
            ST_STOP_A: begin
               if (mid)  sda_q   <= 1'b1;
               if (tick) state_q <= ST_STOP_B;
            end
            ST_STOP_B: begin
               if (tick) begin
                  state_q <= ST_STOP_C;
                  sda_q   <= 1'b0;
               end
            end
            ST_STOP_C: begin
               if (tick) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign scl_oe = (state_q == ST_LO) || (state_q == ST_WAIT) || (state_q == ST_STOP_A);
   assign sda_oe = sda_q;
   assign busy   = (state_q != ST_IDLE);
   assign nack   = nack_q;

endmodule

// File: rtl/i2c_tx_engine_chk.sv
module i2c_tx_engine_chk #(
   parameter int unsigned HALF_STD  = 1000,
   parameter int unsigned HALF_FAST = 250
) (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic fast_sel,
   input logic start_cmd,
   input logic scl_oe,
   input logic sda_oe,
   input logic busy,
   input logic nack
);

   int unsigned hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                hi_cnt <= 0;
      else if (!busy || scl_oe)  hi_cnt <= 0;
      else                       hi_cnt <= hi_cnt + 1;
   end

   p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!scl_oe && !sda_oe));

   p_start_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && en && start_cmd) |=> (busy && sda_oe && !scl_oe));

   p_start_from_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sda_oe) && !scl_oe && $past(!scl_oe)) |-> $past(!busy));

   p_stop_in_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sda_oe) && !scl_oe && $past(!scl_oe)) |-> busy);

   p_no_joint_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_oe != $past(scl_oe)) |-> $stable(sda_oe));

   p_release_after_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(!scl_oe) && $past(!sda_oe)));

   p_nack_sampled_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nack) |-> $past(busy && !scl_oe));

   p_half_period_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(scl_oe) && busy) |-> (hi_cnt == (fast_sel ? HALF_FAST : HALF_STD)));

   p_en_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !en) |=> !busy);

endmodule

bind i2c_tx_engine i2c_tx_engine_chk #(
   .HALF_STD (HALF_STD),
   .HALF_FAST(HALF_FAST)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .en       (en),
   .fast_sel (fast_sel),
   .start_cmd(start_cmd),
   .scl_oe   (scl_oe),
   .sda_oe   (sda_oe),
   .busy     (busy),
   .nack     (nack)
);

// File: tb/tb_i2c_tx_engine.sv
`timescale 1ns/1ps
module tb_i2c_tx_engine;

   localparam int unsigned HS = 10;
   localparam int unsigned HF = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b1, fast_sel = 1'b0, ack_mode = 1'b1;
   logic start_cmd = 1'b0, stop_arm = 1'b0, data_wr = 1'b0;
   logic [7:0] data_in = 8'h00;
   logic sda_in, scl_oe, sda_oe, busy, nack;

   logic ack_drv = 1'b0;
   logic slave_nack = 1'b0;
   logic mon_ack = 1'b1;
   int   exp_half = HS;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   assign sda_in = !(sda_oe || ack_drv);

   i2c_tx_engine #(.HALF_STD(HS), .HALF_FAST(HF)) dut (
      .clk(clk), .rst_n(rst_n), .en(en), .fast_sel(fast_sel), .ack_mode(ack_mode),
      .start_cmd(start_cmd), .stop_arm(stop_arm), .data_wr(data_wr), .data_in(data_in),
      .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .nack(nack)
   );

   // bus monitor acting as the target
   logic p_scl = 1'b1, p_sda = 1'b1, in_xfer = 1'b0;
   logic [7:0] sh = 8'h00;
   logic [7:0] mon_bytes [4];
   int mon_nb = 0, pc = 0, rises = 0, mon_pulses = 0, hi = 0;
   int starts = 0, stops = 0, viol = 0, hibad = 0;

   always @(negedge clk) begin
      logic scl_l, sda_l;
      scl_l = !scl_oe;
      sda_l = sda_in;
      if (rst_n) begin
         if (scl_l && p_scl) begin
            if (!sda_l && p_sda) begin
               if (in_xfer) viol++;
               in_xfer = 1'b1; pc = 0; rises = 0; hi = 1; starts++;
            end else if (sda_l && !p_sda) begin
               if (!in_xfer) viol++;
               in_xfer = 1'b0; stops++; mon_pulses = rises - 1;
            end else begin
               hi++;
            end
         end else if (scl_l && !p_scl) begin
            if (sda_l != p_sda) viol++;
            hi = 1; rises++;
            if (pc < 8) sh = {sh[6:0], sda_l};
            pc++;
            if (pc == (mon_ack ? 9 : 8)) begin
               if (mon_nb < 4) mon_bytes[mon_nb] = sh;
               mon_nb++; pc = 0;
            end
         end else if (!scl_l && p_scl) begin
            if (sda_l != p_sda) viol++;
            if (in_xfer && hi != exp_half) hibad++;
            hi = 0;
            ack_drv = mon_ack && (pc == 8) && !slave_nack;
         end
      end
      p_scl = scl_l; p_sda = sda_l;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic mon_clear();
      mon_nb = 0; starts = 0; stops = 0; viol = 0; hibad = 0; mon_pulses = 0;
   endtask

   task automatic pulse_stop();
      @(negedge clk) stop_arm = 1'b1;
      @(negedge clk) stop_arm = 1'b0;
   endtask

   task automatic pulse_data(input logic [7:0] b);
      @(negedge clk) begin data_wr = 1'b1; data_in = b; end
      @(negedge clk) data_wr = 1'b0;
   endtask

   // leaves the bench at the falling edge just after the edge that took start_cmd
   task automatic start_xfer(input logic [7:0] b);
      pulse_data(b);
      start_cmd = 1'b1;
      @(negedge clk) start_cmd = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 5000; i++) begin
         if (!busy) break;
         @(negedge clk);
      end
   endtask

   task automatic wait_parked(input int n);
      for (int i = 0; i < 5000; i++) begin
         if (mon_nb >= n && scl_oe) break;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      chk(!scl_oe && !sda_oe, "R1 lines released after reset", {scl_oe, sda_oe}, 0);
      chk(!busy && !nack, "R1 busy/nack low after reset", {busy, nack}, 0);
   endtask

   task automatic t_start_timing();
      mon_clear(); ack_mode = 1'b1; mon_ack = 1'b1; fast_sel = 1'b0; exp_half = HS;
      start_xfer(8'hA4);
      chk(busy && sda_oe && !scl_oe, "R2 START one cycle after command",
          {busy, sda_oe, scl_oe}, 3'b110);
      repeat (HS - 1) @(negedge clk);
      chk(!scl_oe, "R2 SCL still high before half-period", scl_oe, 0);
      @(negedge clk);
      chk(scl_oe, "R2 SCL low after one half-period", scl_oe, 1);
      pulse_stop();
      wait_idle();
      chk(mon_nb == 1 && mon_bytes[0] == 8'hA4, "R3 address byte MSB first", mon_bytes[0], 8'hA4);
      chk(mon_pulses == 9, "R3 nine pulses in ack mode", mon_pulses, 9);
      chk(!nack, "R3 acked byte leaves nack low", nack, 0);
      chk(stops == 1 && !scl_oe && !sda_oe, "R6 STOP then lines released", stops, 1);
      chk(viol == 0, "R4 SDA changes only with SCL low", viol, 0);
      chk(hibad == 0, "R9 standard half-period", hibad, 0);
   endtask

   task automatic t_two_bytes();
      mon_clear();
      start_xfer(8'h5A);
      wait_parked(1);
      repeat (2 * HS) @(negedge clk);
      chk(busy && scl_oe && mon_nb == 1, "R5 parked with SCL low after byte", mon_nb, 1);
      pulse_data(8'h3C);
      pulse_stop();
      wait_idle();
      chk(mon_nb == 2 && mon_bytes[1] == 8'h3C, "R5 loaded byte sent automatically",
          mon_bytes[1], 8'h3C);
      chk(mon_pulses == 18, "R3 two bytes take eighteen pulses", mon_pulses, 18);
      chk(viol == 0, "R4 no illegal SDA change in two-byte transfer", viol, 0);
   endtask

   task automatic t_ignored_load();
      mon_clear();
      start_xfer(8'h81);
      repeat (3 * HS) @(negedge clk);
      pulse_data(8'hFF);
      wait_parked(1);
      repeat (4 * HS) @(negedge clk);
      chk(mon_nb == 1 && mon_bytes[0] == 8'h81, "R5 write during byte ignored",
          mon_bytes[0], 8'h81);
      chk(busy && scl_oe, "R5 no extra byte after ignored write", mon_nb, 1);
      pulse_stop();
      wait_idle();
      chk(stops == 1, "R6 stop from parked state", stops, 1);
   endtask

   task automatic t_stop_idle_ignored();
      mon_clear();
      pulse_stop();
      start_xfer(8'hC3);
      wait_parked(1);
      repeat (2 * HS) @(negedge clk);
      chk(busy && stops == 0, "R6 stop armed while idle ignored", stops, 0);
      pulse_stop();
      wait_idle();
      chk(stops == 1 && !busy, "R6 later stop completes", stops, 1);
   endtask

   task automatic t_nack_armed();
      mon_clear(); slave_nack = 1'b1;
      start_xfer(8'hA5);
      pulse_stop();
      wait_idle();
      chk(nack, "R7 nack latched on missing ACK", nack, 1);
      chk(stops == 1 && mon_nb == 1, "R7 armed stop after NACK", stops, 1);
   endtask

   task automatic t_nack_hold();
      mon_clear(); slave_nack = 1'b1;
      start_xfer(8'h11);
      wait_parked(1);
      repeat (3 * HS) @(negedge clk);
      chk(busy && scl_oe && nack, "R7 NACK without stop parks with SCL low",
          {busy, scl_oe, nack}, 3'b111);
      chk(stops == 0, "R7 no STOP without arming", stops, 0);
      pulse_stop();
      wait_idle();
      slave_nack = 1'b0;
   endtask

   task automatic t_noack();
      mon_clear(); ack_mode = 1'b0; mon_ack = 1'b0;
      start_xfer(8'h96);
      chk(!nack, "R7 nack cleared by START", nack, 0);
      wait_parked(1);
      pulse_data(8'h0F);
      pulse_stop();
      wait_idle();
      chk(mon_nb == 2 && mon_bytes[0] == 8'h96 && mon_bytes[1] == 8'h0F,
          "R8 bytes in no-ack mode", mon_bytes[1], 8'h0F);
      chk(mon_pulses == 16, "R8 eight pulses per byte", mon_pulses, 16);
      chk(viol == 0, "R4 no illegal SDA change in no-ack mode", viol, 0);
      ack_mode = 1'b1; mon_ack = 1'b1;
   endtask

   task automatic t_fast();
      mon_clear(); fast_sel = 1'b1; exp_half = HF;
      start_xfer(8'hE7);
      pulse_stop();
      wait_idle();
      chk(hibad == 0, "R9 fast half-period", hibad, 0);
      chk(mon_nb == 1 && mon_bytes[0] == 8'hE7 && mon_pulses == 9, "R9 fast byte content",
          mon_bytes[0], 8'hE7);
      fast_sel = 1'b0; exp_half = HS;
   endtask

   task automatic t_en_low();
      mon_clear(); en = 1'b0;
      @(negedge clk) start_cmd = 1'b1;
      @(negedge clk) start_cmd = 1'b0;
      repeat (2 * HS) @(negedge clk);
      chk(!busy && !scl_oe && !sda_oe && starts == 0, "R10 start ignored when disabled",
          {busy, scl_oe, sda_oe}, 0);
      en = 1'b1;
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_start_timing();
      t_two_bytes();
      t_ignored_load();
      t_stop_idle_ignored();
      t_nack_armed();
      t_nack_hold();
      t_noack();
      t_fast();
      t_en_low();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule